// File: doc/BRIEF.md
# MDIO Management Master with PHY Discovery

This block manages external PHY devices over a two-wire serial management bus. It drives the management clock (MDC), derived from the system clock, and a bidirectional data line (MDIO). A request gives a read/write select, a 5-bit PHY address, a 5-bit register address and 16 bits of write data. The master builds the whole serial frame, handles the bus turnaround, checks the acknowledge bit and returns a 16-bit result together with a one-cycle done pulse and an error flag.

A discovery request scans the PHY address space in ascending order. At each address it reads the first identifier register and stops at the first address that returns a value other than all zeros or all ones. It reports that address and the identifier value. PHY addresses at or above the filter limit are never put on the bus. Such a request completes at once.

The data line is modelled as separate output, output-enable and input pins. An external pull-up keeps the line high while it is released.

Top module: `mdio_master`

## Requirements
- R1: After reset, busy, rsp_done, mdc and mdio_oe are low, and rsp_rdata, rsp_err and rsp_phy are zero.
- R2: Every bus frame starts with 32 driven one bits. These are followed, MSB first, by the start code 01, the opcode (read 10, write 01), the 5-bit PHY address and the 5-bit register address.
- R3: One MDC period lasts 2*HALF_DIV system cycles, with half of it high. MDIO and its output enable never change while MDC is high. The master changes its output bits only on the falling MDC edge.
- R4: On a read, the line is released for 17 bit periods after the register address. The first of these is the acknowledge bit and the next 16 are data, MSB first. The master samples each one at the end of the MDC high phase. A read whose acknowledge is 0 returns the sampled data with rsp_err low.
- R5: A read whose acknowledge bit samples as 1 returns rsp_rdata = 0 with rsp_err high.
- R6: On a write, the master drives the turnaround bits 10 and then the 16 data bits MSB first. Every frame ends with one driven idle bit of value 1, after which MDC is low and the line is released.
- R7: A request with a PHY address of 17 or more makes no MDC edge. It raises rsp_done on the cycle after it is accepted, with rsp_rdata = 0 and rsp_err high.
- R8: busy is high from the cycle after a request is accepted through the rsp_done cycle. rsp_done lasts one cycle. A start pulse while busy is ignored. While busy is low, MDC and mdio_oe stay low.
- R9: A discovery request reads register 2 at PHY addresses 0, 1, 2, ... in order and stops at the first value that is neither 0x0000 nor 0xFFFF. A non-acknowledged read counts as 0x0000. The result is that address on rsp_phy, the value on rsp_rdata and rsp_err low.
- R10: If no address from 0 through 16 qualifies, the discovery completes after 17 frames with rsp_err high and rsp_rdata = 0.
- R11: rsp_done follows the accepting clock edge by 1 + L*2*HALF_DIV cycles for each frame performed, where L is 64 for a read and 65 for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | Request strobe, accepted when not busy |
| req_write | input | 1 | 1 = register write, 0 = register read |
| req_scan | input | 1 | 1 = discovery scan (other request fields ignored) |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Write data |
| rsp_rdata | output | 16 | Read data or discovered identifier |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | No acknowledge, filtered address, or no PHY found |
| rsp_phy | output | 5 | Address found by the last discovery |
| busy | output | 1 | Request in progress |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
A wrong bit counter or a wrongly loaded frame register shows up as a bad preamble, start code, opcode or address field. The bus model in the bench catches this at the 46th MDC rise of the frame. A divider or phase fault changes the spacing between MDC rises, so it is caught at the second rise. A controller stuck in the wrong state shows up as MDC activity while busy is low, or as a done pulse on the wrong cycle; both are compared every clock. A scan sequencing error shows up as the wrong address in the next frame header, one frame after the error.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_XFER,
    ST_SCAN,
    ST_DONE
  } mgmt_state_e;

  localparam logic [1:0] SOF_CODE = 2'b01;
  localparam logic [1:0] OP_RD    = 2'b10;
  localparam logic [1:0] OP_WR    = 2'b01;
  localparam logic [1:0] TA_WR    = 2'b10;
  localparam logic       IDLE_BIT = 1'b1;

endpackage

// File: rtl/mdio_clkdiv.sv
module mdio_clkdiv #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic half_tick
);

  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    half_tick = run && (cnt_q == CW'(HALF_DIV - 1));
    if (!run || half_tick) cnt_d = '0;
    else                   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
#(
  parameter int PRE_LEN  = 32,
  parameter int AW       = 5,
  parameter int DW       = 16,
  parameter int HALF_DIV = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          wr,
  input  logic [AW-1:0] phy,
  input  logic [AW-1:0] regad,
  input  logic [DW-1:0] wdata,
  input  logic          mdio_i,
  output logic          mdc,
  output logic          mdio_o,
  output logic          mdio_oe,
  output logic          fin,
  output logic [DW-1:0] rdata,
  output logic          ack_bad
);

  localparam int HDR_W   = 4 + 2 * AW;
  localparam int HDR_END = PRE_LEN + HDR_W;
  localparam int RD_LEN  = HDR_END + DW + 2;
  localparam int WR_LEN  = HDR_END + DW + 3;
  localparam int CNT_W   = $clog2(WR_LEN);
  localparam int TOP     = WR_LEN - 1;

  logic             active_q, active_d;
  logic             phase_q, phase_d;
  logic             wr_q, wr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [TOP:0]     out_q, out_d, oe_q, oe_d;
  logic [DW:0]      in_q, in_d;
  logic [TOP:0]     ld_out, ld_oe;
  logic [HDR_W-1:0] hdr;
  logic             tick, at_last;

  mdio_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (active_q),
    .half_tick (tick)
  );

  always_comb begin
    hdr    = {SOF_CODE, (wr ? OP_WR : OP_RD), phy, regad};
    ld_out = wr ? {{PRE_LEN{1'b1}}, hdr, TA_WR, wdata, IDLE_BIT}
                : {{PRE_LEN{1'b1}}, hdr, {(DW+1){1'b0}}, IDLE_BIT, 1'b0};
    ld_oe  = wr ? {WR_LEN{1'b1}}
                : {{HDR_END{1'b1}}, {(DW+1){1'b0}}, 2'b10};
    at_last = (cnt_q == (wr_q ? CNT_W'(WR_LEN - 1) : CNT_W'(RD_LEN - 1)));
  end

  always_comb begin
    active_d = active_q;
    phase_d  = phase_q;
    wr_d     = wr_q;
    cnt_d    = cnt_q;
    out_d    = out_q;
    oe_d     = oe_q;
    in_d     = in_q;
    fin      = 1'b0;
    if (go && !active_q) begin
      active_d = 1'b1;
      phase_d  = 1'b0;
      wr_d     = wr;
      cnt_d    = '0;
      out_d    = ld_out;
      oe_d     = ld_oe;
    end else if (active_q && tick) begin
      if (!phase_q) begin
        phase_d = 1'b1;
      end else begin
        phase_d = 1'b0;
        if (!oe_q[TOP]) in_d = {in_q[DW-1:0], mdio_i};
        out_d = out_q << 1;
        oe_d  = oe_q << 1;
        cnt_d = cnt_q + 1'b1;
        if (at_last) begin
          active_d = 1'b0;
          fin      = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      phase_q  <= 1'b0;
      wr_q     <= 1'b0;
      cnt_q    <= '0;
      out_q    <= '0;
      oe_q     <= '0;
      in_q     <= '0;
    end else begin
      active_q <= active_d;
      phase_q  <= phase_d;
      wr_q     <= wr_d;
      cnt_q    <= cnt_d;
      out_q    <= out_d;
      oe_q     <= oe_d;
      in_q     <= in_d;
    end
  end

  assign mdc     = active_q & phase_q;
  assign mdio_o  = active_q & out_q[TOP];
  assign mdio_oe = active_q & oe_q[TOP];
  assign rdata   = in_q[DW-1:0];
  assign ack_bad = in_q[DW];

  // R3: data line frozen while the management clock is high
  a_r3_hold_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  // R6: after the last bit the clock is low and the line released
  a_r6_release_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> (!mdio_oe && !mdc));

endmodule

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int AW         = 5,
  parameter int DW         = 16,
  parameter int ADDR_LIMIT = 17,
  parameter int ID_REG     = 2,
  parameter int SCAN_LAST  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          wr,
  input  logic          scan,
  input  logic [AW-1:0] phy,
  input  logic [AW-1:0] regad,
  input  logic [DW-1:0] wdata,
  input  logic          fr_fin,
  input  logic [DW-1:0] fr_rdata,
  input  logic          fr_ackbad,
  output logic          go,
  output logic          cmd_wr,
  output logic [AW-1:0] cmd_phy,
  output logic [AW-1:0] cmd_reg,
  output logic [DW-1:0] cmd_wdata,
  output logic          busy,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic          err,
  output logic [AW-1:0] found
);

  mgmt_state_e   state_q, state_d;
  logic          go_q, go_d;
  logic          wr_q, wr_d;
  logic [AW-1:0] phy_q, phy_d, reg_q, reg_d, found_q, found_d;
  logic [DW-1:0] wdata_q, wdata_d, rdata_q, rdata_d;
  logic          err_q, err_d;
  logic [DW-1:0] read_ok;

  always_comb begin
    state_d = state_q;
    go_d    = 1'b0;
    wr_d    = wr_q;
    phy_d   = phy_q;
    reg_d   = reg_q;
    wdata_d = wdata_q;
    rdata_d = rdata_q;
    err_d   = err_q;
    found_d = found_q;
    read_ok = fr_ackbad ? '0 : fr_rdata;
    case (state_q)
      ST_IDLE: if (start) begin
        wdata_d = wdata;
        if (scan) begin
          wr_d    = 1'b0;
          phy_d   = '0;
          reg_d   = AW'(ID_REG);
          go_d    = 1'b1;
          state_d = ST_SCAN;
        end else begin
          wr_d  = wr;
          phy_d = phy;
          reg_d = regad;
          if (int'(phy) >= ADDR_LIMIT) begin
            rdata_d = '0;
            err_d   = 1'b1;
            state_d = ST_DONE;
          end else begin
            go_d    = 1'b1;
            state_d = ST_XFER;
          end
        end
      end
      ST_XFER: if (fr_fin) begin
        state_d = ST_DONE;
        rdata_d = wr_q ? '0 : read_ok;
        err_d   = wr_q ? 1'b0 : fr_ackbad;
      end
      ST_SCAN: if (fr_fin) begin
        if (read_ok != '0 && read_ok != '1) begin
          rdata_d = read_ok;
          err_d   = 1'b0;
          found_d = phy_q;
          state_d = ST_DONE;
        end else if (phy_q == AW'(SCAN_LAST)) begin
          rdata_d = '0;
          err_d   = 1'b1;
          found_d = phy_q;
          state_d = ST_DONE;
        end else begin
          phy_d = phy_q + 1'b1;
          go_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      go_q    <= 1'b0;
      wr_q    <= 1'b0;
      phy_q   <= '0;
      reg_q   <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
      found_q <= '0;
    end else begin
      state_q <= state_d;
      go_q    <= go_d;
      wr_q    <= wr_d;
      phy_q   <= phy_d;
      reg_q   <= reg_d;
      wdata_q <= wdata_d;
      rdata_q <= rdata_d;
      err_q   <= err_d;
      found_q <= found_d;
    end
  end

  assign go        = go_q;
  assign cmd_wr    = wr_q;
  assign cmd_phy   = phy_q;
  assign cmd_reg   = reg_q;
  assign cmd_wdata = wdata_q;
  assign busy      = (state_q != ST_IDLE);
  assign done      = (state_q == ST_DONE);
  assign rdata     = rdata_q;
  assign err       = err_q;
  assign found     = found_q;

  // R8: a start pulse during a request leaves the command untouched
  a_r8_ignore_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && state_q != ST_SCAN) |=> ($stable(phy_q) && $stable(reg_q) && $stable(wr_q)));

  // R7: filtered address completes next cycle without a frame
  a_r7_filtered: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && start && !scan && int'(phy) >= ADDR_LIMIT) |=> (done && err && !go_q));

  // R5: a missing acknowledge forces zero data and the error flag
  a_r5_nack_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_XFER && fr_fin && !wr_q && fr_ackbad) |=> (rdata == '0 && err));

  // R9: the scan visits addresses in ascending order
  a_r9_scan_step: assert property (@(posedge clk) disable iff (!rst_n)
    (go_q && state_q == ST_SCAN && $past(state_q) == ST_SCAN) |-> (phy_q == $past(phy_q) + 1'b1));

  // R10: the scan never passes its last address
  a_r10_scan_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SCAN) |-> (int'(phy_q) <= SCAN_LAST));

endmodule

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int HALF_DIV   = 4,
  parameter int PRE_LEN    = 32,
  parameter int AW         = 5,
  parameter int DW         = 16,
  parameter int ADDR_LIMIT = 17,
  parameter int ID_REG     = 2,
  parameter int SCAN_LAST  = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_start,
  input  logic          req_write,
  input  logic          req_scan,
  input  logic [AW-1:0] req_phy,
  input  logic [AW-1:0] req_reg,
  input  logic [DW-1:0] req_wdata,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_done,
  output logic          rsp_err,
  output logic [AW-1:0] rsp_phy,
  output logic          busy,
  output logic          mdc,
  output logic          mdio_o,
  output logic          mdio_oe,
  input  logic          mdio_i
);

  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  logic          go, cmd_wr, fr_fin, fr_ackbad;
  logic [AW-1:0] cmd_phy, cmd_reg;
  logic [DW-1:0] cmd_wdata, fr_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  mdio_ctrl #(
    .AW(AW), .DW(DW), .ADDR_LIMIT(ADDR_LIMIT), .ID_REG(ID_REG), .SCAN_LAST(SCAN_LAST)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start     (req_start),
    .wr        (req_write),
    .scan      (req_scan),
    .phy       (req_phy),
    .regad     (req_reg),
    .wdata     (req_wdata),
    .fr_fin    (fr_fin),
    .fr_rdata  (fr_rdata),
    .fr_ackbad (fr_ackbad),
    .go        (go),
    .cmd_wr    (cmd_wr),
    .cmd_phy   (cmd_phy),
    .cmd_reg   (cmd_reg),
    .cmd_wdata (cmd_wdata),
    .busy      (busy),
    .done      (rsp_done),
    .rdata     (rsp_rdata),
    .err       (rsp_err),
    .found     (rsp_phy)
  );

  mdio_frame #(
    .PRE_LEN(PRE_LEN), .AW(AW), .DW(DW), .HALF_DIV(HALF_DIV)
  ) u_frame (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .go      (go),
    .wr      (cmd_wr),
    .phy     (cmd_phy),
    .regad   (cmd_reg),
    .wdata   (cmd_wdata),
    .mdio_i  (mdio_i),
    .mdc     (mdc),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .fin     (fr_fin),
    .rdata   (fr_rdata),
    .ack_bad (fr_ackbad)
  );

endmodule

// File: tb/test_mdio_master.sv
module test_mdio_master;

  localparam int H   = 4;
  localparam int RDC = 1 + 64 * 2 * H;
  localparam int WRC = 1 + 65 * 2 * H;

  logic        clk, rst_n;
  logic        req_start, req_write, req_scan;
  logic [4:0]  req_phy, req_reg;
  logic [15:0] req_wdata;
  logic [15:0] rsp_rdata;
  logic        rsp_done, rsp_err, busy, mdc, mdio_o, mdio_oe, mdio_i;
  logic [4:0]  rsp_phy;

  int errs = 0;
  int checks = 0;
  int rises = 0;
  bit finished = 0;

  bit          present [32];
  logic [15:0] mem [32][32];
  bit          g_wr, g_scan;
  int          g_phy, g_reg;

  mdio_master #(.HALF_DIV(H)) i_mdio_master (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_write(req_write),
    .req_scan(req_scan), .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_phy(rsp_phy),
    .busy(busy), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_phys();
    for (int a = 0; a < 32; a++) begin
      present[a] = 0;
      for (int r = 0; r < 32; r++) mem[a][r] = 16'h0000;
    end
  endtask

  // Behavioural PHY and bus monitor, evaluated away from the active edge
  initial begin : bus_model
    bit prev_mdc, prev_o, prev_oe, is_rd, allp;
    int k, flen, cyc, last_rise;
    bit ob [65];
    bit obe [65];
    logic [15:0] wd;
    logic [4:0] fp, fr;
    logic [1:0] fs, fo;
    prev_mdc = 0; prev_o = 0; prev_oe = 0; is_rd = 1;
    k = 0; flen = 65; cyc = 0; last_rise = 0; wd = '0; fp = '0; fr = '0;
    mdio_i = 1'b1;
    forever begin
      @(negedge clk);
      cyc++;
      if (!rst_n) begin
        k = 0; prev_mdc = 0; mdio_i = 1'b1;
      end else begin
        if (!busy) chk(!mdc && !mdio_oe, "R8 bus quiet when not busy", {mdc, mdio_oe}, 0);
        if (mdc && prev_mdc)
          chk(mdio_o == prev_o && mdio_oe == prev_oe, "R3 data stable while mdc high",
              {mdio_o, mdio_oe}, {prev_o, prev_oe});
        if (mdc && !prev_mdc) begin
          rises++;
          if (k > 0) chk(cyc - last_rise == 2 * H, "R3 mdc period", cyc - last_rise, 2 * H);
          last_rise = cyc;
          ob[k] = mdio_o; obe[k] = mdio_oe;
          if (k == 45) begin
            allp = 1;
            for (int j = 0; j < 32; j++) if (!(ob[j] && obe[j])) allp = 0;
            chk(allp, "R2 preamble of 32 ones", allp, 1);
            allp = 1;
            for (int j = 32; j < 46; j++) if (!obe[j]) allp = 0;
            chk(allp, "R2 header driven", allp, 1);
            fs = {ob[32], ob[33]};
            fo = {ob[34], ob[35]};
            fp = '0; fr = '0;
            for (int j = 0; j < 5; j++) begin
              fp = {fp[3:0], ob[36 + j]};
              fr = {fr[3:0], ob[41 + j]};
            end
            chk(fs == 2'b01, "R2 start code", fs, 2'b01);
            chk(fo == (g_wr ? 2'b01 : 2'b10), "R2 opcode", fo, g_wr ? 2'b01 : 2'b10);
            chk(fp == 5'(g_phy), "R2 phy address", fp, g_phy);
            chk(fr == 5'(g_reg), "R2 register address", fr, g_reg);
            is_rd = (fo == 2'b10);
            flen = is_rd ? 64 : 65;
          end
          if (k >= 46) begin
            if (is_rd) begin
              if (k <= 62) chk(!mdio_oe, "R4 line released for ack and data", mdio_oe, 0);
              else chk(mdio_oe && mdio_o, "R6 idle bit after read", {mdio_oe, mdio_o}, 2'b11);
            end else begin
              if (k == 46) chk(mdio_oe && mdio_o, "R6 turnaround first bit", {mdio_oe, mdio_o}, 2'b11);
              else if (k == 47) chk(mdio_oe && !mdio_o, "R6 turnaround second bit", {mdio_oe, mdio_o}, 2'b10);
              else if (k <= 63) begin
                chk(mdio_oe, "R6 data driven", mdio_oe, 1);
                wd = {wd[14:0], mdio_o};
              end else begin
                chk(mdio_oe && mdio_o, "R6 idle bit after write", {mdio_oe, mdio_o}, 2'b11);
                if (present[fp]) mem[fp][fr] = wd;
              end
            end
          end
          if (is_rd && k >= 46 && k <= 62 && present[fp]) begin
            if (k == 46) mdio_i = 1'b0;
            else mdio_i = mem[fp][fr][62 - k];
          end else begin
            mdio_i = 1'b1;
          end
          if (k >= 45 && k == flen - 1) begin
            k = 0;
            if (g_scan) g_phy++;
          end else begin
            k++;
          end
        end
        prev_mdc = mdc; prev_o = mdio_o; prev_oe = mdio_oe;
      end
    end
  end

  task automatic do_req(input bit w, input bit s, input int p, input int r, input int wdv,
                        input bit poke, input int exp_n, input int exp_rd, input bit exp_err,
                        input int exp_ph, input int exp_rises, input string req);
    int n, r0;
    g_wr = w && !s; g_scan = s; g_phy = s ? 0 : p; g_reg = s ? 2 : r;
    r0 = rises;
    req_start = 1; req_write = w; req_scan = s;
    req_phy = 5'(p); req_reg = 5'(r); req_wdata = 16'(wdv);
    @(negedge clk);
    req_start = 0; req_scan = 0;
    chk(busy, {req, " R8 busy after accept"}, busy, 1);
    n = 0;
    while (!rsp_done && n < 20000) begin
      if (poke && n == 5) begin
        req_start = 1; req_write = 1; req_phy = 5'd12; req_reg = 5'd2; req_wdata = 16'hDEAD;
      end
      @(negedge clk);
      req_start = 0;
      n++;
    end
    chk(n == exp_n, {req, " R11 done latency"}, n, exp_n);
    chk(rsp_rdata == 16'(exp_rd), {req, " result data"}, rsp_rdata, exp_rd);
    chk(rsp_err == exp_err, {req, " error flag"}, rsp_err, exp_err);
    chk(busy, {req, " R8 busy during done"}, busy, 1);
    chk(rises - r0 == exp_rises, {req, " mdc rising edges"}, rises - r0, exp_rises);
    if (s) chk(rsp_phy == 5'(exp_ph), {req, " found address"}, rsp_phy, exp_ph);
    @(negedge clk);
    chk(!rsp_done && !busy, {req, " R8 done is one pulse"}, {rsp_done, busy}, 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errs++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errs, checks + 1);
      $finish;
    end
  end

  initial begin : main
    rst_n = 0; req_start = 0; req_write = 0; req_scan = 0;
    req_phy = '0; req_reg = '0; req_wdata = '0;
    g_wr = 0; g_scan = 0; g_phy = 0; g_reg = 0;
    clear_phys();
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(!busy && !rsp_done && !mdc && !mdio_oe, "R1 control outputs after reset",
        {busy, rsp_done, mdc, mdio_oe}, 0);
    chk(rsp_rdata == 0 && !rsp_err && rsp_phy == 0, "R1 result outputs after reset",
        {rsp_rdata, rsp_err, rsp_phy}, 0);

    present[5] = 1;  mem[5][2]  = 16'h0000;
    present[9] = 1;  mem[9][2]  = 16'hFFFF;
    present[12] = 1; mem[12][2] = 16'h0141;
    present[16] = 1; mem[16][2] = 16'h2000; mem[16][3] = 16'h5C90;

    // R4 plain read
    do_req(0, 0, 12, 2, 0, 0, RDC, 16'h0141, 0, 0, 64, "R4 read phy12");
    // R6 write then read back
    do_req(1, 0, 12, 7, 16'hA5C3, 0, WRC, 0, 0, 0, 65, "R6 write phy12");
    do_req(0, 0, 12, 7, 0, 0, RDC, 16'hA5C3, 0, 0, 64, "R6 readback phy12");
    // R4 highest legal address
    do_req(0, 0, 16, 3, 0, 0, RDC, 16'h5C90, 0, 0, 64, "R4 read phy16");
    // R5 absent PHY
    do_req(0, 0, 4, 2, 0, 0, RDC, 0, 1, 0, 64, "R5 read absent phy4");
    // R7 filtered addresses
    do_req(0, 0, 17, 2, 0, 0, 0, 0, 1, 0, 0, "R7 read phy17");
    do_req(1, 0, 31, 7, 16'h1234, 0, 0, 0, 1, 0, 0, "R7 write phy31");
    // R8 start while busy is ignored
    do_req(0, 0, 12, 2, 0, 1, RDC, 16'h0141, 0, 0, 64, "R8 read with poke");
    do_req(0, 0, 12, 2, 0, 0, RDC, 16'h0141, 0, 0, 64, "R8 poke had no effect");
    // R9 scan stops at first valid identifier (skips 0x0000 and 0xFFFF)
    do_req(0, 1, 0, 0, 0, 0, 13 * RDC, 16'h0141, 0, 12, 13 * 64, "R9 scan finds phy12");
    // R9 scan finds the last address
    present[5] = 0; present[9] = 0; present[12] = 0;
    do_req(0, 1, 0, 0, 0, 0, 17 * RDC, 16'h2000, 0, 16, 17 * 64, "R9 scan finds phy16");
    // R10 scan with no PHY
    clear_phys();
    do_req(0, 1, 0, 0, 0, 0, 17 * RDC, 0, 1, 16, 17 * 64, "R10 scan finds none");

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

endmodule